// File: doc/BRIEF.md
# Dual Legacy Timer/Counter

This block holds two 16-bit timer/counter channels. Each channel is kept as a high byte and a low byte. The two channels share one mode register, one run register and one clock-select register. Each channel counts one of two things: a selectable internal timebase, or falling edges on its own external count pin. A gate pin can qualify counting, so the hardware can time the high phase of an external pulse. Each channel sets an overflow flag when its count wraps. A flag stays set until the explicit clear input for that channel is pulsed.

There are four counting modes:

- a 13-bit counter built from five low bits and the high byte;
- a full 16-bit counter;
- an 8-bit counter that reloads from the high byte;
- a split mode that turns channel 0 into two independent 8-bit counters.

In split mode, the second half of channel 0 takes over the run bit and the overflow flag of channel 1. Every count and divider runs on the system clock. The prescalers only produce single-cycle enable pulses, and the pins pass through a synchronizer before any edge is detected. Count bytes can be written at any time. A byte write takes the place of an increment in the same cycle.

Top module: `tmr_pair`

## Requirements
- R1: A channel advances only in a cycle where its run bit is 1 and its qualifying event occurs, and either its gate bit is 0 or its synchronized gate pin is high. With the gate bit at 1 and the gate pin low, the count holds. Run bits are written through `run_wdata`, with bit 0 for channel 0 and bit 1 for channel 1.
- R2: Setting a run bit does not clear the count. Counting resumes from the value held.
- R3: With the channel's external-select bit at 1, the channel advances once for each high-to-low transition of its count pin, and rising transitions are ignored.
- R4: With the external-select bit at 0, the channel advances on its timebase. The timebase is every system clock cycle when the channel's system-clock bit is 1. Otherwise the shared 2-bit prescale code picks it: 00 gives system clock /12, 01 gives /4, 10 gives /48, and 11 gives external clock rising edges /8. The clock-select register is laid out as bits[1:0] prescale code, bit 2 channel 0 system-clock bit, and bit 3 channel 1 system-clock bit.
- R5: Mode code 00 is a 13-bit counter. Its low part is count bits [4:0] and its high part is bits [15:8]. Bits [7:5] hold their value. When the 13-bit value wraps to zero, the overflow flag is set.
- R6: Mode code 01 is a 16-bit counter. When it wraps from 0xFFFF to 0x0000, the overflow flag is set.
- R7: Mode code 10 counts in the low byte. When the low byte passes 0xFF, it is loaded with the high byte and the overflow flag is set. The high byte is not changed by counting.
- R8: Mode code 11 on channel 0 splits it into two counters. The low byte uses channel 0's controls and flag. The high byte counts channel 0's internal timebase whenever channel 1's run bit is 1, ignores the gate, and sets channel 1's flag when it wraps from 0xFF. In this mode channel 1 never sets its own flag.
- R9: Channel 1 in mode code 11 holds its count.
- R10: A pulse on `flag_clr[i]` clears overflow flag i, unless a new overflow sets it in the same cycle.
- R11: After reset, both counts, both flags and all configuration registers are zero.
- R12: The mode register holds channel 0 in bits [3:0] and channel 1 in bits [7:4]. Each nibble is laid out as {gate, external-select, mode[1:0]}. `cnt_wr` bit 0 writes channel 0 low, bit 1 channel 0 high, bit 2 channel 1 low and bit 3 channel 1 high. A byte write takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_pin | input | 2 | External count pins, one per channel |
| gate_pin | input | 2 | External gate pins, one per channel |
| ext_clk | input | 1 | External reference clock for prescale code 11 |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write data |
| clksel_wr | input | 1 | Clock-select register write strobe |
| clksel_wdata | input | 4 | Clock-select register write data |
| run_wr | input | 1 | Run register write strobe |
| run_wdata | input | 2 | Run bits |
| cnt_wr | input | 4 | Count byte write strobes |
| cnt_wdata | input | 8 | Count byte write data |
| flag_clr | input | 2 | Overflow flag clear pulses |
| t0_count | output | 16 | Channel 0 count {high, low} |
| t1_count | output | 16 | Channel 1 count {high, low} |
| ovf_flag | output | 2 | Overflow flags |

## Verification
The hardest situation to reach is one where several count sources are active at once with a known phase. One case is the split mode, where the high half of channel 0 counts on channel 1's run bit while channel 1 itself is frozen. The other is a prescaled timebase whose divider phase cannot be seen from the ports. The stimulus opens run windows whose length is a whole multiple of each divider ratio, so the number of ticks inside a window does not depend on phase. The split case is driven by starting both run bits in one write, with both halves of channel 0 preloaded just below their wrap point. Random start values and window lengths in the 13-bit, 16-bit and reload modes are checked against closed-form counts computed in the bench.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_13    = 2'b00,
    MODE_16    = 2'b01,
    MODE_RLD   = 2'b10,
    MODE_SPLIT = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e mode;
  } chan_cfg_t;

  typedef struct packed {
    logic [15:0] cnt;
    logic        wrap;
  } step_t;

  localparam int CFG_W = $bits(chan_cfg_t);

  // Advance the main counter of one channel by one event.
  function automatic step_t main_step(tmr_mode_e m, logic [15:0] c);
    step_t      r;
    logic [12:0] v13;
    r = '{cnt: c, wrap: 1'b0};
    v13 = '0;
    case (m)
      MODE_13: begin
        v13    = {c[15:8], c[4:0]} + 13'd1;
        r.cnt  = {v13[12:5], c[7:5], v13[4:0]};
        r.wrap = &{c[15:8], c[4:0]};
      end
      MODE_16: begin
        r.cnt  = c + 16'd1;
        r.wrap = &c;
      end
      MODE_RLD: begin
        if (&c[7:0]) begin
          r.cnt  = {c[15:8], c[15:8]};
          r.wrap = 1'b1;
        end else begin
          r.cnt  = {c[15:8], c[7:0] + 8'd1};
        end
      end
      default: begin
        r.cnt  = {c[15:8], c[7:0] + 8'd1};
        r.wrap = &c[7:0];
      end
    endcase
    return r;
  endfunction

  // 8-bit increment with carry-out in bit 8.
  function automatic logic [8:0] byte_step(logic [7:0] b);
    return {&b, b + 8'd1};
  endfunction

endpackage

// File: rtl/tmr_sync.sv
`timescale 1ns/1ps
module tmr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter int KIND   = 0   // 0: level, 1: falling edge, 2: rising edge
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] ev
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= pin;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  generate
    if (KIND == 0) begin : g_level
      assign ev = stg[STAGES-1];
    end else begin : g_edge
      logic [W-1:0] prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stg[STAGES-1];
      end
      if (KIND == 1) begin : g_fall
        assign ev = prev_q & ~stg[STAGES-1];
      end else begin : g_rise
        assign ev = ~prev_q & stg[STAGES-1];
      end

      // R3: an edge event lasts a single cycle per bit
      assert_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((ev & $past(ev)) == '0));
    end
  endgenerate

endmodule

// File: rtl/tmr_timebase.sv
`timescale 1ns/1ps
module tmr_div #(
  parameter int N = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int W = (N > 1) ? $clog2(N) : 1;
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] q;

  assign tick = en && (q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (en)  q <= tick ? '0 : q + 1'b1;
  end

  // R4: a divided timebase never produces two ticks back to back
  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((N > 1) && tick) |=> !tick);
endmodule

module tmr_timebase #(
  parameter int DIV0 = 12,
  parameter int DIV1 = 4,
  parameter int DIV2 = 48,
  parameter int DIVX = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_rise,
  output logic [3:0] tick
);
  generate
    for (genvar i = 0; i < 4; i++) begin : g_div
      localparam int N = (i == 0) ? DIV0 : (i == 1) ? DIV1 : (i == 2) ? DIV2 : DIVX;
      tmr_div #(.N(N)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   ((i == 3) ? ext_rise : 1'b1),
        .tick (tick[i])
      );
    end
  endgenerate
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  tmr_mode_e   mode,
  input  logic        inc_main,
  input  logic        inc_split,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [7:0]  wdata,
  output logic [15:0] cnt,
  output logic        wrap_main,
  output logic        wrap_split
);

  logic [15:0] cnt_q, cnt_d;
  step_t       st;
  logic [8:0]  hi_st;

  always_comb begin
    st    = main_step(mode, cnt_q);
    hi_st = byte_step(cnt_q[15:8]);
    cnt_d = cnt_q;
    if (inc_main)  cnt_d = st.cnt;
    if (inc_split) cnt_d[15:8] = hi_st[7:0];
    if (wr_lo)     cnt_d[7:0]  = wdata;
    if (wr_hi)     cnt_d[15:8] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt        = cnt_q;
  assign wrap_main  = inc_main & st.wrap;
  assign wrap_split = inc_split & hi_st[8];

  // R1: without an event or a write the count holds
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_main && !inc_split && !wr_lo && !wr_hi) |=> $stable(cnt));

  // R5: a 13-bit wrap clears both parts and keeps bits [7:5]
  assert_wrap13_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_main && mode == MODE_13 && !wr_lo && !wr_hi) |=>
      (cnt[15:8] == 8'h00 && cnt[4:0] == 5'h00 && cnt[7:5] == $past(cnt[7:5])));

  // R7: a reload wrap copies the high byte into the low byte
  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_main && mode == MODE_RLD && !wr_lo) |=> (cnt[7:0] == $past(cnt[15:8])));

endmodule

// File: rtl/tmr_pair.sv
`timescale 1ns/1ps
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int PRE_DIV0    = 12,
  parameter int PRE_DIV1    = 4,
  parameter int PRE_DIV2    = 48,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cnt_pin,
  input  logic [1:0]  gate_pin,
  input  logic        ext_clk,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_wdata,
  input  logic        clksel_wr,
  input  logic [3:0]  clksel_wdata,
  input  logic        run_wr,
  input  logic [1:0]  run_wdata,
  input  logic [3:0]  cnt_wr,
  input  logic [7:0]  cnt_wdata,
  input  logic [1:0]  flag_clr,
  output logic [15:0] t0_count,
  output logic [15:0] t1_count,
  output logic [1:0]  ovf_flag
);

  localparam int NCH = 2;

  logic [2*CFG_W-1:0] cfg_q;
  logic [3:0]         clksel_q;
  logic [1:0]         run_q;
  logic [1:0]         flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      clksel_q <= '0;
      run_q    <= '0;
    end else begin
      if (cfg_wr)    cfg_q    <= cfg_wdata;
      if (clksel_wr) clksel_q <= clksel_wdata;
      if (run_wr)    run_q    <= run_wdata;
    end
  end

  // Synchronized pin events
  logic [1:0] cnt_fall;
  logic [1:0] gate_lvl;
  logic       ext_rise;

  tmr_sync #(.W(2), .STAGES(SYNC_STAGES), .KIND(1)) u_sync_cnt (
    .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .ev(cnt_fall));
  tmr_sync #(.W(2), .STAGES(SYNC_STAGES), .KIND(0)) u_sync_gate (
    .clk(clk), .rst_n(rst_n), .pin(gate_pin), .ev(gate_lvl));
  tmr_sync #(.W(1), .STAGES(SYNC_STAGES), .KIND(2)) u_sync_ext (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk), .ev(ext_rise));

  logic [3:0] pre_tick;
  tmr_timebase #(.DIV0(PRE_DIV0), .DIV1(PRE_DIV1), .DIV2(PRE_DIV2), .DIVX(EXT_DIV)) u_tb (
    .clk(clk), .rst_n(rst_n), .ext_rise(ext_rise), .tick(pre_tick));

  // Per-channel qualification
  chan_cfg_t   ch_cfg     [NCH];
  logic [NCH-1:0] tb_tick, active, inc_main, inc_split, wrap_main, wrap_split;
  logic [15:0] ch_cnt     [NCH];
  logic        t0_split;

  assign t0_split = (ch_cfg[0].mode == MODE_SPLIT);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign ch_cfg[i]    = chan_cfg_t'(cfg_q[i*CFG_W +: CFG_W]);
      assign tb_tick[i]   = clksel_q[2+i] ? 1'b1 : pre_tick[clksel_q[1:0]];
      assign active[i]    = run_q[i] & (~ch_cfg[i].gate | gate_lvl[i]);
      if (i == 0) begin : g_t0
        assign inc_main[i]  = active[i] & (ch_cfg[i].ext ? cnt_fall[i] : tb_tick[i]);
        assign inc_split[i] = t0_split & run_q[1] & tb_tick[0];
      end else begin : g_t1
        assign inc_main[i]  = active[i] & (ch_cfg[i].ext ? cnt_fall[i] : tb_tick[i])
                              & (ch_cfg[i].mode != MODE_SPLIT);
        assign inc_split[i] = 1'b0;
      end

      tmr_channel u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (ch_cfg[i].mode),
        .inc_main  (inc_main[i]),
        .inc_split (inc_split[i]),
        .wr_lo     (cnt_wr[2*i]),
        .wr_hi     (cnt_wr[2*i+1]),
        .wdata     (cnt_wdata),
        .cnt       (ch_cnt[i]),
        .wrap_main (wrap_main[i]),
        .wrap_split(wrap_split[i])
      );
    end
  endgenerate

  // Overflow flags: a set in the same cycle wins over a clear
  logic [1:0] flag_set;
  assign flag_set[0] = wrap_main[0];
  assign flag_set[1] = t0_split ? wrap_split[0] : (wrap_main[1] | wrap_split[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else begin
      for (int i = 0; i < NCH; i++) begin
        if (flag_set[i])      flag_q[i] <= 1'b1;
        else if (flag_clr[i]) flag_q[i] <= 1'b0;
      end
    end
  end

  assign t0_count = ch_cnt[0];
  assign t1_count = ch_cnt[1];
  assign ovf_flag = flag_q;

  // R6: a wrap of channel 0 leaves its flag set
  assert_flag0_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_main[0] |=> ovf_flag[0]);

  // R1: gate low with gating on freezes channel 0
  assert_gate_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_cfg[0].gate && !gate_lvl[0] && !t0_split && cnt_wr[1:0] == 2'b00) |=> $stable(t0_count));

  // R8: in split mode channel 1 cannot raise its own flag
  assert_split_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_split && !wrap_split[0] && !ovf_flag[1]) |=> !ovf_flag[1]);

  // R9: channel 1 in mode 11 holds
  assert_t1_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_cfg[1].mode == MODE_SPLIT && cnt_wr[3:2] == 2'b00) |=> $stable(t1_count));

  // R10: a clear without a concurrent set drops the flag
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[0] && !wrap_main[0]) |=> !ovf_flag[0]);

endmodule

// File: tb/tb_tmr_pair.sv
`timescale 1ns/1ps
module tb_tmr_pair;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cnt_pin = 2'b11;
  logic [1:0]  gate_pin = 2'b11;
  logic        ext_clk = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        clksel_wr = 1'b0;
  logic [3:0]  clksel_wdata = '0;
  logic        run_wr = 1'b0;
  logic [1:0]  run_wdata = '0;
  logic [3:0]  cnt_wr = '0;
  logic [7:0]  cnt_wdata = '0;
  logic [1:0]  flag_clr = '0;
  logic [15:0] t0_count, t1_count;
  logic [1:0]  ovf_flag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_pair dut (
    .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .gate_pin(gate_pin), .ext_clk(ext_clk),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .clksel_wr(clksel_wr), .clksel_wdata(clksel_wdata),
    .run_wr(run_wr), .run_wdata(run_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .flag_clr(flag_clr), .t0_count(t0_count), .t1_count(t1_count), .ovf_flag(ovf_flag));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic set_clk(logic [3:0] d);
    @(negedge clk); clksel_wr = 1'b1; clksel_wdata = d;
    @(negedge clk); clksel_wr = 1'b0;
  endtask

  task automatic set_run(logic [1:0] d);
    @(negedge clk); run_wr = 1'b1; run_wdata = d;
    @(negedge clk); run_wr = 1'b0;
  endtask

  task automatic put_cnt(int ch, logic [15:0] v);
    @(negedge clk); cnt_wr = 4'b0001 << (2*ch); cnt_wdata = v[7:0];
    @(negedge clk); cnt_wr = 4'b0010 << (2*ch); cnt_wdata = v[15:8];
    @(negedge clk); cnt_wr = 4'b0000;
  endtask

  task automatic clr_flags();
    @(negedge clk); flag_clr = 2'b11;
    @(negedge clk); flag_clr = 2'b00;
  endtask

  // Exactly n clock edges see the run bits set
  task automatic run_for(logic [1:0] bits, int n);
    @(negedge clk); run_wr = 1'b1; run_wdata = bits;
    @(negedge clk); run_wr = 1'b0;
    repeat (n - 1) @(negedge clk);
    run_wr = 1'b1; run_wdata = 2'b00;
    @(negedge clk); run_wr = 1'b0;
  endtask

  // Closed-form model: {flag, count} after n events from s in mode m
  function automatic logic [16:0] expect_after(logic [1:0] m, logic [15:0] s, int n);
    int total, rem, span;
    logic [15:0] r;
    logic f;
    r = s; f = 1'b0;
    case (m)
      2'b00: begin
        total = {s[15:8], s[4:0]} + n;
        f = (total >= 8192);
        total = total % 8192;
        r = {total[12:5], s[7:5], total[4:0]};
      end
      2'b01: begin
        total = s + n;
        f = (total >= 65536);
        r = total[15:0];
      end
      default: begin
        if (n < 256 - s[7:0]) r = {s[15:8], s[7:0] + n[7:0]};
        else begin
          rem = n - (256 - s[7:0]);
          span = 256 - s[15:8];
          total = s[15:8] + (rem % span);
          r = {s[15:8], total[7:0]};
          f = 1'b1;
        end
      end
    endcase
    return {f, r};
  endfunction

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog actual=timeout expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [16:0] e;
    void'($urandom(32'd4242));
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    // R11: reset values
    chk("R11 t0", t0_count, 0);
    chk("R11 t1", t1_count, 0);
    chk("R11 flags", ovf_flag, 0);

    // R6 / R4: 16-bit on system clock
    set_clk(4'b1100);
    set_cfg(8'h11);
    put_cnt(0, 16'hFFF0);
    run_for(2'b01, 20);
    chk("R6 count", t0_count, 16'h0004);
    chk("R6 flag", ovf_flag[0], 1);
    // R2: restart keeps the count
    run_for(2'b01, 5);
    chk("R2 resume", t0_count, 16'h0009);
    // R10: clear
    clr_flags();
    chk("R10 clear", ovf_flag, 0);

    // R5: 13-bit, bits [7:5] kept
    set_cfg(8'h10);
    put_cnt(0, 16'hFFFE);
    run_for(2'b01, 2);
    chk("R5 count", t0_count, 16'h00E0);
    chk("R5 flag", ovf_flag[0], 1);
    clr_flags();

    // R7: reload
    set_cfg(8'h12);
    put_cnt(0, 16'h80FD);
    run_for(2'b01, 5);
    chk("R7 count", t0_count, 16'h8082);
    chk("R7 flag", ovf_flag[0], 1);
    clr_flags();

    // R4: prescale codes
    set_cfg(8'h11);
    set_clk(4'b0000); put_cnt(0, 0); run_for(2'b01, 120);
    chk("R4 div12", t0_count, 10);
    set_clk(4'b0001); put_cnt(0, 0); run_for(2'b01, 40);
    chk("R4 div4", t0_count, 10);
    set_clk(4'b0010); put_cnt(0, 0); run_for(2'b01, 480);
    chk("R4 div48", t0_count, 10);
    set_clk(4'b0011); put_cnt(0, 0);
    @(negedge clk); run_wr = 1'b1; run_wdata = 2'b01;
    @(negedge clk); run_wr = 1'b0;
    for (int k = 0; k < 16; k++) begin
      ext_clk = 1'b1; idle(3); ext_clk = 1'b0; idle(3);
    end
    idle(8);
    set_run(2'b00);
    chk("R4 ext div8", t0_count, 2);

    // R3: external count pin falling edges
    set_clk(4'b1100);
    set_cfg(8'h15);
    put_cnt(0, 16'h0100);
    @(negedge clk); run_wr = 1'b1; run_wdata = 2'b01;
    @(negedge clk); run_wr = 1'b0;
    for (int k = 0; k < 6; k++) begin
      cnt_pin[0] = 1'b0; idle(4); cnt_pin[0] = 1'b1; idle(4);
    end
    idle(6);
    set_run(2'b00);
    chk("R3 falls", t0_count, 16'h0106);

    // R1: gate
    set_cfg(8'h19);
    put_cnt(0, 0);
    gate_pin[0] = 1'b0; idle(5);
    run_for(2'b01, 20);
    chk("R1 gate low holds", t0_count, 0);
    gate_pin[0] = 1'b1; idle(5);
    run_for(2'b01, 20);
    chk("R1 gate high counts", t0_count, 20);

    // R8 / R9: split channel 0, channel 1 in mode 11
    set_cfg(8'h33);
    put_cnt(0, 16'hFEFE);
    put_cnt(1, 16'h1234);
    clr_flags();
    run_for(2'b11, 3);
    chk("R8 split count", t0_count, 16'h0101);
    chk("R8 split flags", ovf_flag, 2'b11);
    chk("R9 t1 hold", t1_count, 16'h1234);
    clr_flags();
    // R8: high half runs on channel 1 run bit only
    put_cnt(0, 16'h1010);
    run_for(2'b10, 4);
    chk("R8 hi only", t0_count, 16'h1410);

    // R12: write during counting wins
    set_cfg(8'h11);
    put_cnt(0, 16'h0000);
    @(negedge clk); run_wr = 1'b1; run_wdata = 2'b01;
    @(negedge clk); run_wr = 1'b0;
    idle(3);
    cnt_wr = 4'b0001; cnt_wdata = 8'h55;
    @(negedge clk); cnt_wr = 4'b0000;
    run_wr = 1'b1; run_wdata = 2'b00;
    @(negedge clk); run_wr = 1'b0;
    chk("R12 write priority", t0_count, 16'h0056);

    // Random windows on both channels, modes 00/01/10
    for (int it = 0; it < 24; it++) begin
      int ch, n;
      logic [1:0] m;
      logic [15:0] s;
      ch = $urandom_range(0, 1);
      m  = 2'($urandom_range(0, 2));
      s  = 16'($urandom);
      n  = $urandom_range(1, 600);
      set_cfg({2'b00, m, 2'b00, m});
      put_cnt(ch, s);
      clr_flags();
      run_for(ch == 0 ? 2'b01 : 2'b10, n);
      e = expect_after(m, s, n);
      if (m == 2'b00) chk("R5 random", ch == 0 ? t0_count : t1_count, e[15:0]);
      else if (m == 2'b01) chk("R6 random", ch == 0 ? t0_count : t1_count, e[15:0]);
      else chk("R7 random", ch == 0 ? t0_count : t1_count, e[15:0]);
      chk("R10 random flag", ovf_flag[ch], e[16]);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule